// File: doc/BRIEF.md
# APS K-byte transmit inserter

This block sets the two automatic-protection-switching bytes, K1 and K2, that go into each outgoing SONET/SDH frame. Software supplies a 13-bit APS code, a 3-bit value for the low field of K2, and several control bits. A hardware request for line remote-defect indication (line RDI) comes from the receive side. The block registers K1 and K2 once per frame on a frame-start strobe. Every frame therefore carries one consistent set of fields, even if the controls change partway through a frame.

The APS field is K1[7:0] together with K2[7:3]. A small source state machine chooses where it comes from. The choice is made at each frame start, and the state shows which source fills the frame now on the wire.

- `SRC_FILL`: a constant fill of all zeros or all ones.
- `SRC_SOFT`: the software APS code.
- `SRC_BABBLE`: a test pattern that changes every frame.

From any state, the next state is chosen at each strobe in priority order. Babbling enabled gives `SRC_BABBLE`. Otherwise, software APS enabled gives `SRC_SOFT`. Otherwise, the next state is `SRC_FILL`. Reset enters `SRC_FILL`. The K2[2:0] field is chosen on its own: either the software low value or the hardware line-RDI code.

Top module: `kbyte_tx_inserter`

## Requirements
- R1: After reset, k1_out = 8'h00 and k2_out = 8'h00, and no frame has been generated yet.
- R2: k1_out and k2_out change only on the clock edge where frame_start is high. On every other cycle they hold their value, whatever the other inputs do.
- R3: With babble_en = 0 and aps_sw_en = 1, a strobe loads k1_out = aps_sw_value[12:5] and k2_out[7:3] = aps_sw_value[4:0]. In this case fill_ones has no effect.
- R4: With babble_en = 0 and aps_sw_en = 0, a strobe loads k1_out and k2_out[7:3] with all ones when fill_ones = 1, or with all zeros when fill_ones = 0.
- R5: With babble_en = 1, babbling wins over both software insertion and fill. A 13-bit pattern P goes out as k1_out = P[12:5] and k2_out[7:3] = P[4:0].
- R6: In the first babbling frame, P = 0. P increases by one on each further babbling frame, wrapping modulo 8192. Two back-to-back babbling frames therefore never carry the same APS field.
- R7: A strobe with babble_en = 0 resets the pattern. The next babbling run starts again at P = 0.
- R8: With k2_sw_en = 1, a strobe loads k2_out[2:0] = k2_sw_value. In this case line_rdi_req has no effect.
- R9: With k2_sw_en = 0, a strobe loads k2_out[2:0] = 3'b110 when line_rdi_req = 1, and 3'b000 when line_rdi_req = 0.
- R10: Babbling never alters k2_out[2:0], which follows R8 and R9 as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe that loads the next frame's K-bytes |
| aps_sw_en | input | 1 | Take the APS field from the software code |
| aps_sw_value | input | 13 | Software APS code; upper 8 bits go to K1, lower 5 bits to K2[7:3] |
| fill_ones | input | 1 | Fill value when software APS is off: 1 = all ones, 0 = all zeros |
| babble_en | input | 1 | Enable the babbling test pattern |
| k2_sw_en | input | 1 | Take K2[2:0] from software |
| k2_sw_value | input | 3 | Software value for K2[2:0] |
| line_rdi_req | input | 1 | Hardware request for line RDI |
| k1_out | output | 8 | K1 byte for the current frame |
| k2_out | output | 8 | K2 byte for the current frame |

## Verification
The hardest case to reach is the restart of the babbling pattern. From the ports, a pattern restart looks just like a pattern that keeps counting, unless the run is broken by a non-babbling frame and then started again. The stimulus runs three babbling frames and checks 0, 1 and 2. It then sends one fill frame and turns babbling back on, and expects the pattern to begin at 0 again. During the babbling frames, software APS is enabled and line RDI is requested. This shows both the priority of babbling and that K2[2:0] stays independent of it.

// File: rtl/kbyte_pkg.sv
package kbyte_pkg;
    localparam int APS_W  = 13;
    localparam int K1_W   = 8;
    localparam int K2HI_W = APS_W - K1_W;
    localparam int K2LO_W = 3;
    localparam logic [K2LO_W-1:0] RDI_CODE  = 3'b110;
    localparam logic [K2LO_W-1:0] IDLE_CODE = 3'b000;

    typedef enum logic [1:0] {
        SRC_FILL   = 2'd0,
        SRC_SOFT   = 2'd1,
        SRC_BABBLE = 2'd2
    } aps_src_e;
endpackage

// File: rtl/kbyte_babble_gen.sv
module kbyte_babble_gen #(
    parameter int PAT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             babble_en,
    output logic [PAT_W-1:0] pattern
);
    logic [PAT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (frame_start) begin
            if (babble_en) cnt_q <= cnt_q + 1'b1;
            else           cnt_q <= '0;
        end
    end

    assign pattern = cnt_q;

    // R6
    pattern_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && babble_en) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R7
    pattern_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !babble_en) |=> (cnt_q == '0));
endmodule

// File: rtl/kbyte_aps_sel.sv
module kbyte_aps_sel
    import kbyte_pkg::*;
#(
    parameter int PAT_W = APS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             babble_en,
    input  logic             aps_sw_en,
    input  logic             fill_ones,
    input  logic [PAT_W-1:0] aps_sw_value,
    input  logic [PAT_W-1:0] pattern,
    output aps_src_e         src_cur,
    output logic [PAT_W-1:0] aps_next
);
    aps_src_e state_q, state_d;

    // next-state choice, babbling first, then software, then fill
    always_comb begin
        if (babble_en)      state_d = SRC_BABBLE;
        else if (aps_sw_en) state_d = SRC_SOFT;
        else                state_d = SRC_FILL;
    end

    // state register, advanced only at frame boundaries
    always_ff @(posedge clk) begin
        if (!rst_n)           state_q <= SRC_FILL;
        else if (frame_start) state_q <= state_d;
    end

    // field content for the state being entered
    always_comb begin
        unique case (state_d)
            SRC_BABBLE: aps_next = pattern;
            SRC_SOFT:   aps_next = aps_sw_value;
            SRC_FILL:   aps_next = {PAT_W{fill_ones}};
            default:    aps_next = '0;
        endcase
    end

    assign src_cur = state_q;

    // R5
    babble_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && babble_en) |=> (state_q == SRC_BABBLE));

    // R2
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(state_q));
endmodule

// File: rtl/kbyte_k2low_sel.sv
module kbyte_k2low_sel
    import kbyte_pkg::*;
(
    input  logic              k2_sw_en,
    input  logic [K2LO_W-1:0] k2_sw_value,
    input  logic              line_rdi_req,
    output logic [K2LO_W-1:0] k2_low_next
);
    always_comb begin
        if (k2_sw_en)          k2_low_next = k2_sw_value;
        else if (line_rdi_req) k2_low_next = RDI_CODE;
        else                   k2_low_next = IDLE_CODE;
    end
endmodule

// File: rtl/kbyte_tx_inserter.sv
module kbyte_tx_inserter
    import kbyte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              aps_sw_en,
    input  logic [APS_W-1:0]  aps_sw_value,
    input  logic              fill_ones,
    input  logic              babble_en,
    input  logic              k2_sw_en,
    input  logic [K2LO_W-1:0] k2_sw_value,
    input  logic              line_rdi_req,
    output logic [K1_W-1:0]   k1_out,
    output logic [7:0]        k2_out
);
    logic [APS_W-1:0]  pattern;
    logic [APS_W-1:0]  aps_next;
    logic [K2LO_W-1:0] k2_low_next;
    aps_src_e          src_cur;

    kbyte_babble_gen #(.PAT_W(APS_W)) u_babble (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .babble_en   (babble_en),
        .pattern     (pattern)
    );

    kbyte_aps_sel #(.PAT_W(APS_W)) u_aps (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .babble_en    (babble_en),
        .aps_sw_en    (aps_sw_en),
        .fill_ones    (fill_ones),
        .aps_sw_value (aps_sw_value),
        .pattern      (pattern),
        .src_cur      (src_cur),
        .aps_next     (aps_next)
    );

    kbyte_k2low_sel u_k2low (
        .k2_sw_en     (k2_sw_en),
        .k2_sw_value  (k2_sw_value),
        .line_rdi_req (line_rdi_req),
        .k2_low_next  (k2_low_next)
    );

    // output bytes, loaded once per frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k1_out <= '0;
            k2_out <= '0;
        end else if (frame_start) begin
            k1_out <= aps_next[APS_W-1:K2HI_W];
            k2_out <= {aps_next[K2HI_W-1:0], k2_low_next};
        end
    end

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(k1_out) && $stable(k2_out)));

    // R3
    soft_aps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !babble_en && aps_sw_en) |=>
        ({k1_out, k2_out[7:3]} == $past(aps_sw_value)));

    // R6
    babble_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && babble_en && src_cur == SRC_BABBLE) |=>
        ({k1_out, k2_out[7:3]} != $past({k1_out, k2_out[7:3]})));

    // R9
    hw_rdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !k2_sw_en && line_rdi_req) |=> (k2_out[2:0] == 3'b110));

    // R8
    sw_k2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && k2_sw_en) |=> (k2_out[2:0] == $past(k2_sw_value)));
endmodule

// File: tb/tb_kbyte_tx_inserter.sv
module tb_kbyte_tx_inserter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        aps_sw_en = 1'b0;
    logic [12:0] aps_sw_value = '0;
    logic        fill_ones = 1'b0;
    logic        babble_en = 1'b0;
    logic        k2_sw_en = 1'b0;
    logic [2:0]  k2_sw_value = '0;
    logic        line_rdi_req = 1'b0;
    logic [7:0]  k1_out;
    logic [7:0]  k2_out;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    kbyte_tx_inserter dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .aps_sw_en    (aps_sw_en),
        .aps_sw_value (aps_sw_value),
        .fill_ones    (fill_ones),
        .babble_en    (babble_en),
        .k2_sw_en     (k2_sw_en),
        .k2_sw_value  (k2_sw_value),
        .line_rdi_req (line_rdi_req),
        .k1_out       (k1_out),
        .k2_out       (k2_out)
    );

    // {aps_en, value[12:0], fill, k2en, k2val[2:0], rdi, expK1[7:0], expK2[7:0]}
    localparam int NV = 8;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 13'h1ABC, 1'b0, 1'b1, 3'd3, 1'b0, 8'hD5, 8'hE3},
        {1'b0, 13'h0000, 1'b1, 1'b0, 3'd0, 1'b1, 8'hFF, 8'hFE},
        {1'b0, 13'h1FFF, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00},
        {1'b0, 13'h0000, 1'b0, 1'b0, 3'd0, 1'b1, 8'h00, 8'h06},
        {1'b1, 13'h1FFF, 1'b0, 1'b1, 3'd0, 1'b0, 8'hFF, 8'hF8},
        {1'b1, 13'h0000, 1'b1, 1'b1, 3'd7, 1'b1, 8'h00, 8'h07},
        {1'b0, 13'h0000, 1'b1, 1'b1, 3'd5, 1'b1, 8'hFF, 8'hFD},
        {1'b1, 13'h0021, 1'b0, 1'b0, 3'd0, 1'b0, 8'h01, 8'h08}
    };

    task automatic check(input string req, input logic [7:0] k1e, input logic [7:0] k2e);
        tests++;
        if (k1_out !== k1e || k2_out !== k2e) begin
            fails++;
            $display("FAIL %s: k1=%h k2=%h expected k1=%h k2=%h", req, k1_out, k2_out, k1e, k2e);
        end
    endtask

    task automatic frame();
        frame_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", 8'h00, 8'h00);

        for (int i = 0; i < NV; i++) begin
            aps_sw_en    = VEC[i][35];
            aps_sw_value = VEC[i][34:22];
            fill_ones    = VEC[i][21];
            k2_sw_en     = VEC[i][20];
            k2_sw_value  = VEC[i][19:17];
            line_rdi_req = VEC[i][16];
            frame();
            check($sformatf("R3/R4/R8/R9 vector %0d", i), VEC[i][15:8], VEC[i][7:0]);
        end

        // R2: inputs move without a strobe, outputs must hold (last vector 01/08)
        aps_sw_en = 1'b0; fill_ones = 1'b1; k2_sw_en = 1'b1; k2_sw_value = 3'd7;
        babble_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 hold without strobe", 8'h01, 8'h08);
        babble_en = 1'b0;

        // R5, R6, R10: babbling beats software APS, RDI still in K2[2:0]
        aps_sw_en = 1'b1; aps_sw_value = 13'h1FFF; k2_sw_en = 1'b0; line_rdi_req = 1'b1;
        babble_en = 1'b1;
        frame();
        check("R5 R10 babble P=0", 8'h00, 8'h06);
        frame();
        check("R6 babble P=1", 8'h00, 8'h0E);
        frame();
        check("R6 babble P=2", 8'h00, 8'h16);

        // R7: leave babbling for one fill frame, then restart
        babble_en = 1'b0; aps_sw_en = 1'b0; fill_ones = 1'b1;
        frame();
        check("R4 fill after babble", 8'hFF, 8'hFE);
        babble_en = 1'b1; k2_sw_en = 1'b1; k2_sw_value = 3'd5;
        frame();
        check("R7 R10 babble restart P=0", 8'h00, 8'h05);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        babble_en = 1'b0;
        @(negedge clk);
        check("R1 reset again", 8'h00, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule